// File: doc/BRIEF.md
# Power Domain Gate Sequencer

This block turns a single power domain on or off on command. It works against an external power-gating state machine: the block drives a gate request bit and then watches a status code that the state machine reports. A command is carried out only if it would change something. When the domain already reads as being in the wanted state, when a force-on override holds it up, or when a global suppression flag forbids the change, the command is answered with a one-cycle "skipped" pulse and the gate bit is left alone.

When a command does proceed, the block first looks at a shared request-enable flag that gates all power requests. If that flag reads 0, it emits a one-cycle request to set it. The block then writes the gate bit and polls the status at a fixed interval. It ends with either a "done" pulse, when the target code is seen, or a "timeout" pulse, when the poll budget runs out. In both cases it records the commanded state in a tracked enable output. A parameter selects one of two domain kinds. A per-pipe domain honours suppression for power-off only and ignores force-on. A shared domain honours force-on and lets suppression block both directions.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, cmd_ready is 1, and gate_bit, tracked_en, done, skipped, timeout and ip_req_set are all 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. The domain reads as on only when pg_status equals 0. A power-on command (cmd_on=1) that finds it on, or a power-off command (cmd_on=0) that finds it not on, gives a skipped pulse in the cycle after acceptance, and gate_bit stays unchanged.
- R3: In the shared kind (DOMAIN_KIND=1), a command accepted while force_on is 1 is skipped without touching gate_bit. In the per-pipe kind (DOMAIN_KIND=0), force_on has no effect.
- R4: While suppress is 1, power-off commands are skipped in both kinds. Power-on commands are skipped in the shared kind and still carried out in the per-pipe kind.
- R5: For a command that is carried out, ip_req_set pulses for one cycle in the cycle after acceptance if ip_req_en was 0 at acceptance. It stays 0 if ip_req_en was 1.
- R6: For a command that is carried out, gate_bit takes the value 0 for power-on or 1 for power-off on the second clock edge after acceptance.
- R7: After gate_bit is written, pg_status is sampled once every POLL_GAP cycles, with the first sample POLL_GAP edges after the gate write. The first sample that equals 0 (power-on) or 2 (power-off) gives a done pulse. Any other code, including the transition code 1, does not.
- R8: If POLL_LIMIT samples in a row miss the target, the last one gives a timeout pulse and the block returns to idle.
- R9: tracked_en takes the commanded value in the same cycle as done or timeout, and keeps its value on a skip.
- R10: cmd_ready is 0 from the cycle after acceptance until done or timeout. A cmd_valid seen while cmd_ready is 0 is ignored.
- R11: done, skipped and timeout are one-cycle pulses, and at most one of them is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_on | input | 1 | 1 requests power-on, 0 requests power-off |
| cmd_ready | output | 1 | Block idle and able to take a command |
| suppress | input | 1 | Combined global ignore / debug-disable / idle-optimisation flag |
| force_on | input | 1 | Domain force-on override (shared kind only) |
| ip_req_en | input | 1 | Current value of the global request-enable flag |
| ip_req_set | output | 1 | One-cycle request to set the global request-enable flag |
| pg_status | input | STAT_W | Status code from the power-gating state machine |
| gate_bit | output | 1 | Gate request: 0 powers on, 1 powers off |
| done | output | 1 | Pulse: target status reached |
| skipped | output | 1 | Pulse: command needed no action or was blocked |
| timeout | output | 1 | Pulse: poll budget exhausted |
| tracked_en | output | 1 | Last commanded on/off state |

## Verification
One command stream drives a per-pipe instance and a shared instance side by side, so each guard variant is told apart by its reaction to the same input. The patterns cover:
- redundant commands, which show the live-status guard;
- force-on during a power-off, which separates the two kinds;
- suppression with power-on and then power-off, which shows the direction asymmetry;
- a frozen status that never leaves the transition code, which separates done from timeout;
- commands held on cmd_valid during a busy sequence, which must be dropped.

Running the power-off and power-on pair with the request-enable flag first clear and then set shows whether its set request is conditional.

// File: rtl/pds_pkg.sv
package pds_pkg;

   localparam int KIND_PIPE   = 0;
   localparam int KIND_SHARED = 1;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ARM  = 2'd1,
      SQ_POLL = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pds_guard.sv
module pds_guard #(
   parameter int STAT_W  = 2,
   parameter int ON_CODE = 0,
   parameter int KIND    = pds_pkg::KIND_PIPE
) (
   input  logic              want_on,
   input  logic              suppress,
   input  logic              force_on,
   input  logic [STAT_W-1:0] status,
   output logic              skip
);

   localparam logic [STAT_W-1:0] ON_V = STAT_W'(ON_CODE);

   logic is_on;
   logic already;
   logic sup_hit;
   logic force_hit;

   assign is_on   = (status == ON_V);
   assign already = want_on ? is_on : !is_on;

   generate
      if (KIND == pds_pkg::KIND_SHARED) begin : g_shared
         assign sup_hit = suppress;
      end else begin : g_pipe
         assign sup_hit = suppress && !want_on;
      end
   endgenerate

   assign force_hit = force_on && (KIND == pds_pkg::KIND_SHARED);
   assign skip      = sup_hit || already || force_hit;

endmodule

// File: rtl/pds_poll.sv
module pds_poll #(
   parameter int GAP   = 2,
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic match,
   output logic fin_ok,
   output logic fin_to
);

   localparam int             PC_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [PC_W-1:0] LAST = PC_W'(LIMIT - 1);

   logic            tick;
   logic [PC_W-1:0] pc_q;

   generate
      if (GAP == 1) begin : g_every
         assign tick = active;
      end else begin : g_div
         localparam int           DW    = $clog2(GAP);
         localparam logic [DW-1:0] DLAST = DW'(GAP - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || start) begin
               div_q <= '0;
            end else if (active) begin
               div_q <= (div_q == DLAST) ? '0 : div_q + 1'b1;
            end
         end
         assign tick = active && (div_q == DLAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         pc_q <= '0;
      end else if (tick && !match && pc_q != LAST) begin
         pc_q <= pc_q + 1'b1;
      end
   end

   assign fin_ok = tick && match;
   assign fin_to = tick && !match && (pc_q == LAST);

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
   parameter int STAT_W      = 2,
   parameter int ST_ON       = 0,
   parameter int ST_OFF      = 2,
   parameter int POLL_GAP    = 2,
   parameter int POLL_LIMIT  = 1000,
   parameter int DOMAIN_KIND = pds_pkg::KIND_PIPE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_on,
   output logic              cmd_ready,
   input  logic              suppress,
   input  logic              force_on,
   input  logic              ip_req_en,
   output logic              ip_req_set,
   input  logic [STAT_W-1:0] pg_status,
   output logic              gate_bit,
   output logic              done,
   output logic              skipped,
   output logic              timeout,
   output logic              tracked_en
);
   import pds_pkg::*;

   localparam logic [STAT_W-1:0] ON_V  = STAT_W'(ST_ON);
   localparam logic [STAT_W-1:0] OFF_V = STAT_W'(ST_OFF);

   generate
      if (STAT_W < 2) begin : g_bad_w
         $error("STAT_W must be at least 2");
      end
      if (POLL_GAP < 1) begin : g_bad_gap
         $error("POLL_GAP must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_lim
         $error("POLL_LIMIT must be at least 1");
      end
      if (ST_ON == ST_OFF) begin : g_bad_codes
         $error("ST_ON and ST_OFF must differ");
      end
      if (DOMAIN_KIND != KIND_PIPE && DOMAIN_KIND != KIND_SHARED) begin : g_bad_kind
         $error("DOMAIN_KIND must be 0 or 1");
      end
   endgenerate

   seq_state_t state_q;
   logic       cmd_q;
   logic       accept;
   logic       skip;
   logic       match;
   logic       fin_ok;
   logic       fin_to;

   assign cmd_ready = (state_q == SQ_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign match     = (pg_status == (cmd_q ? ON_V : OFF_V));

   pds_guard #(
      .STAT_W  (STAT_W),
      .ON_CODE (ST_ON),
      .KIND    (DOMAIN_KIND)
   ) u_guard (
      .want_on  (cmd_on),
      .suppress (suppress),
      .force_on (force_on),
      .status   (pg_status),
      .skip     (skip)
   );

   pds_poll #(
      .GAP   (POLL_GAP),
      .LIMIT (POLL_LIMIT)
   ) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (state_q == SQ_ARM),
      .active (state_q == SQ_POLL),
      .match  (match),
      .fin_ok (fin_ok),
      .fin_to (fin_to)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         cmd_q      <= 1'b0;
         gate_bit   <= 1'b0;
         tracked_en <= 1'b0;
         done       <= 1'b0;
         skipped    <= 1'b0;
         timeout    <= 1'b0;
         ip_req_set <= 1'b0;
      end else begin
         done       <= 1'b0;
         skipped    <= 1'b0;
         timeout    <= 1'b0;
         ip_req_set <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  if (skip) begin
                     skipped <= 1'b1;
                  end else begin
                     state_q    <= SQ_ARM;
                     cmd_q      <= cmd_on;
                     ip_req_set <= !ip_req_en;
                  end
               end
            end
            SQ_ARM: begin
               gate_bit <= !cmd_q;
               state_q  <= SQ_POLL;
            end
            SQ_POLL: begin
               if (fin_ok) begin
                  done       <= 1'b1;
                  tracked_en <= cmd_q;
                  state_q    <= SQ_IDLE;
               end else if (fin_to) begin
                  timeout    <= 1'b1;
                  tracked_en <= cmd_q;
                  state_q    <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pds_checker.sv
module pds_checker (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic ip_req_en,
   input logic ip_req_set,
   input logic gate_bit,
   input logic done,
   input logic skipped,
   input logic timeout,
   input logic tracked_en
);

   p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, skipped, timeout}));

   p_idle_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> cmd_ready);

   p_skip_keeps_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      skipped |-> $stable(gate_bit));

   p_skip_keeps_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
      skipped |-> $stable(tracked_en));

   p_done_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tracked_en == !gate_bit));

   p_set_only_if_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ip_req_set |-> ($past(!ip_req_en) && $past(cmd_valid)));

endmodule

bind pwr_domain_seq pds_checker u_pds_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .ip_req_en  (ip_req_en),
   .ip_req_set (ip_req_set),
   .gate_bit   (gate_bit),
   .done       (done),
   .skipped    (skipped),
   .timeout    (timeout),
   .tracked_en (tracked_en)
);

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;

   localparam int GAP   = 2;
   localparam int LIMIT = 6;
   localparam int LAT   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic cmd_valid = 1'b0, cmd_on = 1'b0, suppress = 1'b0, force_on = 1'b0, freeze = 1'b0;
   logic [1:0] stat [2];
   logic ip_en [2];
   logic rdy [2], ipset [2], gate [2], dn [2], skp [2], tmo [2], trk [2];

   int nchk = 0, nfail = 0;
   int sk_cnt [2], dn_cnt [2], to_cnt [2], ips_cnt [2];

   pwr_domain_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .DOMAIN_KIND(0)) i_pwr_domain_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on), .cmd_ready(rdy[0]),
      .suppress(suppress), .force_on(force_on), .ip_req_en(ip_en[0]), .ip_req_set(ipset[0]),
      .pg_status(stat[0]), .gate_bit(gate[0]), .done(dn[0]), .skipped(skp[0]),
      .timeout(tmo[0]), .tracked_en(trk[0]));

   pwr_domain_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .DOMAIN_KIND(1)) i_pwr_domain_seq_sh (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on), .cmd_ready(rdy[1]),
      .suppress(suppress), .force_on(force_on), .ip_req_en(ip_en[1]), .ip_req_set(ipset[1]),
      .pg_status(stat[1]), .gate_bit(gate[1]), .done(dn[1]), .skipped(skp[1]),
      .timeout(tmo[1]), .tracked_en(trk[1]));

   // environment: power-gating state machine and global request flag
   logic lastg [2];
   int   cnt [2];
   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            stat[k] <= 2'd0; ip_en[k] <= 1'b0; lastg[k] = 1'b0; cnt[k] = 0;
         end else begin
            if (ipset[k]) ip_en[k] <= 1'b1;
            if (gate[k] !== lastg[k]) begin
               lastg[k] = gate[k]; stat[k] <= 2'd1; cnt[k] = LAT;
            end else if (cnt[k] > 0) begin
               cnt[k] = cnt[k] - 1;
            end else if (!freeze && stat[k] == 2'd1) begin
               stat[k] <= lastg[k] ? 2'd2 : 2'd0;
            end
         end
      end
   end

   // behavioural reference model
   int ph [2], wt [2], np [2];
   logic mc [2], mg [2], mt [2], m_dn [2], m_sk [2], m_to [2], m_ips [2];
   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            ph[k] = 0; mc[k] = 0; mg[k] = 0; mt[k] = 0;
            m_dn[k] = 0; m_sk[k] = 0; m_to[k] = 0; m_ips[k] = 0; wt[k] = 0; np[k] = 0;
         end else begin
            m_dn[k] = 0; m_sk[k] = 0; m_to[k] = 0; m_ips[k] = 0;
            if (ph[k] == 0) begin
               if (cmd_valid) begin
                  if ((cmd_on ? (stat[k] == 2'd0) : (stat[k] != 2'd0)) ||
                      (suppress && (k == 1 || !cmd_on)) || (k == 1 && force_on))
                     m_sk[k] = 1;
                  else begin
                     ph[k] = 1; mc[k] = cmd_on; m_ips[k] = !ip_en[k];
                  end
               end
            end else if (ph[k] == 1) begin
               mg[k] = !mc[k]; ph[k] = 2; wt[k] = 0; np[k] = 0;
            end else begin
               wt[k] = wt[k] + 1;
               if (wt[k] == GAP) begin
                  wt[k] = 0;
                  if (stat[k] == (mc[k] ? 2'd0 : 2'd2)) begin
                     m_dn[k] = 1; mt[k] = mc[k]; ph[k] = 0;
                  end else begin
                     np[k] = np[k] + 1;
                     if (np[k] == LIMIT) begin
                        m_to[k] = 1; mt[k] = mc[k]; ph[k] = 0;
                     end
                  end
               end
            end
         end
      end
   end

   task automatic chk(string tag, int k, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s inst%0d actual=%0b expected=%0b t=%0t", tag, k, act, exp, $time);
      end
   endtask

   task automatic chk_int(string tag, int k, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s inst%0d actual=%0d expected=%0d t=%0t", tag, k, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            chk("R10 cmd_ready", k, rdy[k], ph[k] == 0);
            chk("R2 skipped", k, skp[k], m_sk[k]);
            chk("R5 ip_req_set", k, ipset[k], m_ips[k]);
            chk("R6 gate_bit", k, gate[k], mg[k]);
            chk("R7 done", k, dn[k], m_dn[k]);
            chk("R8 timeout", k, tmo[k], m_to[k]);
            chk("R9 tracked_en", k, trk[k], mt[k]);
            chk("R11 exclusive", k, (int'(dn[k]) + int'(skp[k]) + int'(tmo[k])) <= 1, 1'b1);
            if (skp[k]) sk_cnt[k]++;
            if (dn[k]) dn_cnt[k]++;
            if (tmo[k]) to_cnt[k]++;
            if (ipset[k]) ips_cnt[k]++;
         end
      end
   end

   task automatic issue(logic on);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_on = on;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 200 && !(ph[0] == 0 && ph[1] == 0); i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int s0, s1, d0, d1, t0, t1, i0, i1;
      for (int k = 0; k < 2; k++) begin
         sk_cnt[k] = 0; dn_cnt[k] = 0; to_cnt[k] = 0; ips_cnt[k] = 0;
      end
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin    // R1 reset state
         chk("R1 ready", k, rdy[k], 1'b1);
         chk("R1 gate", k, gate[k], 1'b0);
         chk("R1 tracked", k, trk[k], 1'b0);
         chk("R1 pulses", k, dn[k] | skp[k] | tmo[k] | ipset[k], 1'b0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: power-on while already on
      s0 = sk_cnt[0]; s1 = sk_cnt[1];
      issue(1'b1);
      chk_int("R2 redundant on", 0, sk_cnt[0] - s0, 1);
      chk_int("R2 redundant on", 1, sk_cnt[1] - s1, 1);

      // power-off with request flag clear: R5, R6, R7, R9
      d0 = dn_cnt[0]; d1 = dn_cnt[1];
      issue(1'b0);
      for (int k = 0; k < 2; k++) begin
         chk_int("R5 set when clear", k, ips_cnt[k], 1);
         chk("R6 gate off", k, gate[k], 1'b1);
         chk("R9 tracked off", k, trk[k], 1'b0);
      end
      chk_int("R7 done off", 0, dn_cnt[0] - d0, 1);
      chk_int("R7 done off", 1, dn_cnt[1] - d1, 1);

      // R2: power-off while already off
      issue(1'b0);
      // power-on with flag already set: R5 unchanged
      issue(1'b1);
      for (int k = 0; k < 2; k++) begin
         chk_int("R5 no set when set", k, ips_cnt[k], 1);
         chk("R6 gate on", k, gate[k], 1'b0);
         chk("R9 tracked on", k, trk[k], 1'b1);
      end

      // R3: force-on during power-off
      s1 = sk_cnt[1];
      force_on = 1'b1;
      issue(1'b0);
      force_on = 1'b0;
      chk("R3 pipe ignores force", 0, gate[0], 1'b1);
      chk("R3 shared held", 1, gate[1], 1'b0);
      chk_int("R3 shared skip", 1, sk_cnt[1] - s1, 1);

      // R4: suppression with power-on (pipe off, shared on)
      suppress = 1'b1;
      s1 = sk_cnt[1];
      issue(1'b1);
      chk("R4 pipe on proceeds", 0, gate[0], 1'b0);
      chk_int("R4 shared skip", 1, sk_cnt[1] - s1, 1);
      // R4: suppression with power-off
      s0 = sk_cnt[0]; s1 = sk_cnt[1];
      issue(1'b0);
      chk_int("R4 off suppressed", 0, sk_cnt[0] - s0, 1);
      chk_int("R4 off suppressed", 1, sk_cnt[1] - s1, 1);
      suppress = 1'b0;

      // R8: status frozen in transition
      t0 = to_cnt[0]; t1 = to_cnt[1];
      freeze = 1'b1;
      issue(1'b0);
      chk_int("R8 timeout", 0, to_cnt[0] - t0, 1);
      chk_int("R8 timeout", 1, to_cnt[1] - t1, 1);
      chk("R9 tracked after timeout", 0, trk[0], 1'b0);
      freeze = 1'b0;
      repeat (4) @(negedge clk);

      // R10: commands held during busy are ignored
      d0 = dn_cnt[0]; s0 = sk_cnt[0]; i0 = ips_cnt[0]; i1 = ips_cnt[1];
      @(negedge clk);
      cmd_valid = 1'b1; cmd_on = 1'b1;
      @(negedge clk);
      cmd_on = 1'b0;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 200 && !(ph[0] == 0 && ph[1] == 0); i++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk_int("R10 one done", 0, dn_cnt[0] - d0, 1);
      chk_int("R10 no extra skip", 0, sk_cnt[0] - s0, 0);
      chk("R10 final gate", 0, gate[0], 1'b0);
      chk_int("R5 flag stays set", 0, ips_cnt[0] - i0 + ips_cnt[1] - i1, 0);

      repeat (3) @(negedge clk);
      report();
   end

endmodule